// File: doc/BRIEF.md
# EPROM Pulse-and-Verify Programming Sequencer

This controller sits inside a device programmer and writes a byte image into a UV-erasable EPROM. It starts from an erased part, where every bit reads as one. It visits every address in ascending order and fetches the byte to be written from an image source through a request/valid handshake. It then applies fixed-length program pulses, and after each pulse it reads the same address back. An address moves on as soon as its read-back matches the image. An address gets another pulse only while the read-back still differs and the pulse cap has not been reached.

The controller does not generate any supply voltage. It drives two-bit level requests to an external supply. During the pulse phase it asks for the programming VPP and a boosted VCC of 6.25 V. After the last address it switches both requests to 5.25 V and runs a second pass that reads and compares the whole array. Any address that cannot be written, and any mismatch in the second pass, stops the run and reports the failing address.

State names used below: IDLE, RAMP_PROG, FETCH, PULSE, RECOVER, VERIFY, RAMP_CHECK, CHK_FETCH, CHK_READ, HALT. The transitions are:
- IDLE → RAMP_PROG on start.
- RAMP_PROG → FETCH when the settle time expires.
- FETCH → PULSE on img_valid.
- PULSE → RECOVER when the pulse time expires.
- RECOVER → VERIFY when the settle time expires.
- VERIFY → FETCH on a match at an address that is not the last one.
- VERIFY → RAMP_CHECK on a match at the last address.
- VERIFY → PULSE on a mismatch that can still be fixed, below the cap.
- VERIFY → HALT on a bit that cannot be fixed, or when the cap is reached.
- RAMP_CHECK → CHK_FETCH when the settle time expires.
- CHK_FETCH → CHK_READ on img_valid.
- CHK_READ → CHK_FETCH on a match at an address that is not the last one.
- CHK_READ → HALT on a match at the last address, or on a mismatch.
- HALT → RAMP_PROG on start.

Top module: `eprom_burn_seq`

## Requirements
- R1: After reset the outputs are idle: ce_n, oe_n and pgm_n are high; dq_oe, busy, done and fail are low; vpp_sel and vcc_sel are both 2'b00 (nominal).
- R2: A start pulse while idle raises busy and sets vpp_sel=2'b01 (programming VPP) and vcc_sel=2'b01 (6.25 V). These levels are held for exactly SETTLE_CYC cycles before the first image request.
- R3: img_req stays high, with img_addr equal to prog_addr, until img_valid arrives. The byte on img_data is captured in the cycle where img_valid is high.
- R4: Each program pulse holds ce_n=0, pgm_n=0, oe_n=1 and dq_oe=1, with dq_out equal to the image byte. The pulse lasts exactly PULSE_CYC = CLK_MHZ*PULSE_US cycles, and it occurs only while vpp_sel=2'b01 and vcc_sel=2'b01.
- R5: The cycle after a pulse, pgm_n returns high, dq_oe drops, and ce_n and oe_n are low for the read-back. VPP stays at the programming level.
- R6: An address whose read-back equals its image byte is finished. Every address receives at least one pulse. An address advances after the first matching read, so it gets exactly as many pulses as the device needs.
- R7: A mismatch that still needs ones cleared gives another pulse. The gap with pgm_n high between two pulses at one address is SETTLE_CYC+1 cycles. A match on the pulse that equals the cap passes.
- R8: When MAX_PULSES pulses have been given and the read-back still differs, the run stops with fail=1, done=1, and fail_addr set to that address.
- R9: When the image has a 1 where the device reads 0, the run stops at once with fail=1 and fail_addr set, without another pulse.
- R10: Addresses run from 0 to 2**ADDR_W-1 in ascending order. The default of ADDR_W=13 gives 8192 addresses.
- R11: After the last address both levels switch to 2'b10 (5.25 V) for SETTLE_CYC cycles. Then every address is fetched again in ascending order and read back with ce_n=0, oe_n=0, pgm_n=1 and dq_oe=0.
- R12: A mismatch in the check pass stops the run with fail=1 and fail_addr set. If the whole pass matches, done=1 and fail=0.
- R13: After the run, done and fail hold, busy is low and both levels return to 2'b00 until the next start. A start received while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (honoured only when not busy) |
| img_req | output | 1 | Image byte request |
| img_addr | output | ADDR_W | Address of the requested image byte |
| img_valid | input | 1 | Image byte present on img_data |
| img_data | input | 8 | Image byte |
| ce_n | output | 1 | Device chip enable, active low |
| oe_n | output | 1 | Device output enable, active low |
| pgm_n | output | 1 | Device program strobe, active low |
| prog_addr | output | ADDR_W | Device address bus |
| dq_out | output | 8 | Data driven toward the device |
| dq_oe | output | 1 | Drive enable for dq_out |
| dq_in | input | 8 | Data read from the device |
| vpp_sel | output | 2 | VPP level request: 00 nominal, 01 programming, 10 5.25 V |
| vcc_sel | output | 2 | VCC level request: 00 nominal, 01 6.25 V, 10 5.25 V |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | Run ended in failure |
| fail_addr | output | ADDR_W | Address at which the run failed |

## Verification
The verify decision can see a read-back match and a reached pulse cap in the same cycle. The bench provokes this with a device model in which one address needs exactly MAX_PULSES pulses. The match must win: the scoreboard must count exactly the cap number of pulses at that address, and the run must go on without fail. A second coincidence is the match at the last address, which must switch the phase instead of advancing the address. This is judged by the supply levels seen at the first check-pass request and by the restarted address sequence.

// File: rtl/eprom_burn_pkg.sv
package eprom_burn_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP_PROG,
        S_FETCH,
        S_PULSE,
        S_RECOVER,
        S_VERIFY,
        S_RAMP_CHECK,
        S_CHK_FETCH,
        S_CHK_READ,
        S_HALT
    } burn_state_t;

    // supply level request encodings
    localparam logic [1:0] LVL_NOM   = 2'b00;
    localparam logic [1:0] LVL_PROG  = 2'b01; // VPP programming / VCC 6.25 V
    localparam logic [1:0] LVL_CHECK = 2'b10; // 5.25 V on both

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/burn_try_ctr.sv
module burn_try_ctr #(
    parameter int MAX_PULSES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_cap
);
    localparam int CW = $clog2(MAX_PULSES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end

    assign at_cap = (cnt == CW'(MAX_PULSES));

    // R8: the sequencer never pulses an address beyond the cap
    a_r8_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_PULSES));
endmodule

// File: rtl/burn_addr_ctr.sv
module burn_addr_ctr #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr <= '0;
        else if (clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    assign last = &addr;
endmodule

// File: rtl/eprom_burn_seq.sv
module eprom_burn_seq
    import eprom_burn_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int CLK_MHZ    = 100,
    parameter int PULSE_US   = 100,
    parameter int SETTLE_CYC = 16,
    parameter int MAX_PULSES = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              img_req,
    output logic [ADDR_W-1:0] img_addr,
    input  logic              img_valid,
    input  logic [7:0]        img_data,
    output logic              ce_n,
    output logic              oe_n,
    output logic              pgm_n,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    input  logic [7:0]        dq_in,
    output logic [1:0]        vpp_sel,
    output logic [1:0]        vcc_sel,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr
);
    localparam int PULSE_CYC = CLK_MHZ * PULSE_US;
    localparam int TMR_TOP   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int TMR_W     = $clog2(TMR_TOP + 1);
    localparam logic [TMR_W-1:0] T_PULSE  = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC - 1);

    burn_state_t       state, nxt;
    logic [7:0]        data_q;
    logic              fail_q;
    logic [ADDR_W-1:0] fail_addr_q;

    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              addr_clr, addr_inc, addr_last;
    logic [ADDR_W-1:0] addr;
    logic              try_clr, try_inc, try_cap;
    logic              data_cap, set_fail, clr_fail;
    logic              rd_match, rd_stuck;

    burn_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .expired(tmr_done)
    );

    burn_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clr(addr_clr), .inc(addr_inc),
        .addr(addr), .last(addr_last)
    );

    burn_try_ctr #(.MAX_PULSES(MAX_PULSES)) u_tries (
        .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .at_cap(try_cap)
    );

    assign rd_match = (dq_in == data_q);
    assign rd_stuck = |(data_q & ~dq_in);

    // state and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            data_q      <= 8'hFF;
            fail_q      <= 1'b0;
            fail_addr_q <= '0;
        end else begin
            state <= nxt;
            if (data_cap)
                data_q <= img_data;
            if (clr_fail)
                fail_q <= 1'b0;
            else if (set_fail) begin
                fail_q      <= 1'b1;
                fail_addr_q <= addr;
            end
        end
    end

    // next state and control strobes
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = T_SETTLE;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        try_clr  = 1'b0;
        try_inc  = 1'b0;
        data_cap = 1'b0;
        set_fail = 1'b0;
        clr_fail = 1'b0;
        unique case (state)
            S_IDLE, S_HALT: begin
                if (start) begin
                    nxt      = S_RAMP_PROG;
                    tmr_load = 1'b1;
                    addr_clr = 1'b1;
                    clr_fail = 1'b1;
                end
            end
            S_RAMP_PROG: begin
                if (tmr_done) nxt = S_FETCH;
            end
            S_FETCH: begin
                if (img_valid) begin
                    nxt      = S_PULSE;
                    data_cap = 1'b1;
                    try_clr  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            S_PULSE: begin
                if (tmr_done) begin
                    nxt      = S_RECOVER;
                    try_inc  = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            S_RECOVER: begin
                if (tmr_done) nxt = S_VERIFY;
            end
            S_VERIFY: begin
                if (rd_match) begin
                    if (addr_last) begin
                        nxt      = S_RAMP_CHECK;
                        addr_clr = 1'b1;
                        tmr_load = 1'b1;
                    end else begin
                        nxt      = S_FETCH;
                        addr_inc = 1'b1;
                    end
                end else if (rd_stuck || try_cap) begin
                    nxt      = S_HALT;
                    set_fail = 1'b1;
                end else begin
                    nxt      = S_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = T_PULSE;
                end
            end
            S_RAMP_CHECK: begin
                if (tmr_done) nxt = S_CHK_FETCH;
            end
            S_CHK_FETCH: begin
                if (img_valid) begin
                    nxt      = S_CHK_READ;
                    data_cap = 1'b1;
                    tmr_load = 1'b1;
                end
            end
            S_CHK_READ: begin
                if (tmr_done) begin
                    if (!rd_match) begin
                        nxt      = S_HALT;
                        set_fail = 1'b1;
                    end else if (addr_last) begin
                        nxt = S_HALT;
                    end else begin
                        nxt      = S_CHK_FETCH;
                        addr_inc = 1'b1;
                    end
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        ce_n    = 1'b1;
        oe_n    = 1'b1;
        pgm_n   = 1'b1;
        dq_oe   = 1'b0;
        img_req = 1'b0;
        vpp_sel = LVL_NOM;
        vcc_sel = LVL_NOM;
        unique case (state)
            S_IDLE, S_HALT: ;
            S_RAMP_PROG: begin
                vpp_sel = LVL_PROG;
                vcc_sel = LVL_PROG;
            end
            S_FETCH: begin
                vpp_sel = LVL_PROG;
                vcc_sel = LVL_PROG;
                img_req = 1'b1;
            end
            S_PULSE: begin
                vpp_sel = LVL_PROG;
                vcc_sel = LVL_PROG;
                ce_n    = 1'b0;
                pgm_n   = 1'b0;
                dq_oe   = 1'b1;
            end
            S_RECOVER, S_VERIFY: begin
                vpp_sel = LVL_PROG;
                vcc_sel = LVL_PROG;
                ce_n    = 1'b0;
                oe_n    = 1'b0;
            end
            S_RAMP_CHECK: begin
                vpp_sel = LVL_CHECK;
                vcc_sel = LVL_CHECK;
            end
            S_CHK_FETCH: begin
                vpp_sel = LVL_CHECK;
                vcc_sel = LVL_CHECK;
                ce_n    = 1'b0;
                oe_n    = 1'b0;
                img_req = 1'b1;
            end
            S_CHK_READ: begin
                vpp_sel = LVL_CHECK;
                vcc_sel = LVL_CHECK;
                ce_n    = 1'b0;
                oe_n    = 1'b0;
            end
            default: ;
        endcase
    end

    assign img_addr  = addr;
    assign prog_addr = addr;
    assign dq_out    = data_q;
    assign busy      = (state != S_IDLE) && (state != S_HALT);
    assign done      = (state == S_HALT);
    assign fail      = fail_q;
    assign fail_addr = fail_addr_q;

    // R4: a program strobe only with both supplies raised and the bus driven
    a_r4_pulse_conditions: assert property (@(posedge clk) disable iff (!rst_n)
        !pgm_n |-> (vpp_sel == LVL_PROG && vcc_sel == LVL_PROG && !ce_n && oe_n && dq_oe));

    // R5: reading never overlaps driving or programming
    a_r5_bus_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!dq_oe && pgm_n));

    // R10: a finished address is followed by its successor
    a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VERIFY && nxt == S_FETCH) |=> (prog_addr == ADDR_W'($past(prog_addr) + 1'b1)));

    // R12: a failure holds until a new start
    a_r12_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    // R13: supplies at nominal and device deselected whenever not busy
    a_r13_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (vpp_sel == LVL_NOM && vcc_sel == LVL_NOM && ce_n && pgm_n));
endmodule

// File: tb/test_eprom_burn_seq.sv
`timescale 1ns/1ps
module test_eprom_burn_seq;
    localparam int AW     = 3;
    localparam int DEPTH  = 1 << AW;
    localparam int PCYC   = 6;   // CLK_MHZ=1 * PULSE_US=6
    localparam int SETTLE = 3;
    localparam int CAP    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic img_req, img_valid = 1'b0;
    logic [AW-1:0] img_addr, prog_addr, fail_addr;
    logic [7:0] img_data = 8'h00, dq_out, dq_in;
    logic ce_n, oe_n, pgm_n, dq_oe, busy, done, fail;
    logic [1:0] vpp_sel, vcc_sel;

    always #2 clk = ~clk;

    eprom_burn_seq #(
        .ADDR_W(AW), .CLK_MHZ(1), .PULSE_US(PCYC), .SETTLE_CYC(SETTLE), .MAX_PULSES(CAP)
    ) i_eprom_burn_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .img_req(img_req), .img_addr(img_addr), .img_valid(img_valid), .img_data(img_data),
        .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n), .prog_addr(prog_addr),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in),
        .vpp_sel(vpp_sel), .vcc_sel(vcc_sel),
        .busy(busy), .done(done), .fail(fail), .fail_addr(fail_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- device and image models ----------------
    logic [7:0] img [DEPTH];
    logic [7:0] mem [DEPTH];
    int need [DEPTH];
    int got  [DEPTH];
    bit in_pulse = 0;
    int lat_a = 0;
    logic [7:0] lat_d = 8'hFF;
    int img_lat = 0;

    assign dq_in = (!ce_n && !oe_n && !dq_oe) ? mem[prog_addr] : 8'h00;

    always @(negedge clk) begin
        if (!pgm_n && !ce_n && vpp_sel == 2'b01) begin
            in_pulse = 1;
            lat_a = int'(prog_addr);
            lat_d = dq_out;
        end else if (in_pulse) begin
            in_pulse = 0;
            got[lat_a]++;
            if (got[lat_a] >= need[lat_a]) mem[lat_a] = mem[lat_a] & lat_d;
        end
        if (img_valid) img_valid = 1'b0;
        else if (img_req) begin
            if (img_lat == 0) begin
                img_valid = 1'b1;
                img_data  = img[img_addr];
                img_lat   = int'(img_addr) % 3;
            end else img_lat--;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct { int addr; int pulses; } exp_t;
    exp_t q[$];
    int cur_addr = -1;
    int cur_cnt = 0;
    int wcnt = 0;
    int hcnt = 0;
    int exp_pa = 0;
    int exp_ca = 0;
    logic pgm_prev = 1'b1;
    logic req_prev = 1'b0;

    task automatic sb_close();
        exp_t e;
        if (cur_addr >= 0) begin
            if (q.size() == 0) chk(0, "R6 unexpected address", cur_addr, -1);
            else begin
                e = q.pop_front();
                chk(e.addr == cur_addr, "R10 pulsed address order", cur_addr, e.addr);
                chk(e.pulses == cur_cnt, "R6/R7 pulses per address", cur_cnt, e.pulses);
            end
        end
        cur_addr = -1;
        cur_cnt = 0;
    endtask

    // driver side: expected pulse count from the device model before the run
    task automatic push_expect(input int last_a);
        exp_t e;
        for (int a = 0; a <= last_a; a++) begin
            e.addr = a;
            if ((img[a] & ~mem[a]) != 8'h00) e.pulses = 1;
            else if (mem[a] == img[a]) e.pulses = 1;
            else e.pulses = (need[a] > CAP) ? CAP : need[a];
            q.push_back(e);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (!pgm_n) begin
                if (pgm_prev) begin
                    if (cur_addr == int'(prog_addr))
                        chk(hcnt == SETTLE + 1, "R7 gap between pulses", hcnt, SETTLE + 1);
                    wcnt = 0;
                end
                wcnt++;
                chk(dq_out == img[prog_addr], "R4 data during pulse", dq_out, img[prog_addr]);
            end else if (!pgm_prev) begin
                chk(wcnt == PCYC, "R4 pulse width", wcnt, PCYC);
                chk(!oe_n && !dq_oe && vpp_sel == 2'b01, "R5 read-back after pulse",
                    {oe_n, dq_oe, vpp_sel}, 4'b0001);
                if (cur_addr != int'(prog_addr)) begin
                    sb_close();
                    cur_addr = int'(prog_addr);
                end
                cur_cnt++;
                hcnt = 1;
            end else hcnt++;
            if (img_req && !req_prev) begin
                chk(prog_addr == img_addr, "R3 request address on device bus", prog_addr, img_addr);
                if (vcc_sel == 2'b01) begin
                    chk(int'(img_addr) == exp_pa, "R10 program address order", img_addr, exp_pa);
                    exp_pa++;
                end else begin
                    chk(vcc_sel == 2'b10 && vpp_sel == 2'b10, "R11 check levels",
                        {vpp_sel, vcc_sel}, 4'b1010);
                    chk(int'(img_addr) == exp_ca, "R11 check address order", img_addr, exp_ca);
                    chk(pgm_n && !dq_oe && !ce_n && !oe_n, "R11 read setup",
                        {pgm_n, dq_oe, ce_n, oe_n}, 4'b1000);
                    exp_ca++;
                end
            end
            pgm_prev = pgm_n;
            req_prev = img_req;
        end
    end

    // ---------------- stimulus ----------------
    task automatic setup(input int variant);
        for (int a = 0; a < DEPTH; a++) begin
            img[a]  = 8'h3C ^ 8'(a * 37);
            mem[a]  = 8'hFF;
            got[a]  = 0;
        end
        img[3] = 8'hFF;
        need[0] = 1; need[1] = 2; need[2] = CAP; need[3] = 1;
        need[4] = 3; need[5] = 4; need[6] = 1; need[7] = 2;
        if (variant == 2) need[5] = CAP + 2;
        if (variant == 3) begin
            img[2] = img[2] | 8'h08;
            mem[2] = 8'hF7;
        end
        if (variant == 4) img[6] = img[6] | 8'h80;
    endtask

    task automatic run_case(input int last_a, input bit exp_fail, input int exp_fa,
                            input int corrupt, input bit poke_start, input int exp_cpass);
        int n;
        bit corrupted;
        push_expect(last_a);
        exp_pa = 0;
        exp_ca = 0;
        cur_addr = -1;
        cur_cnt = 0;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && vpp_sel == 2'b01 && vcc_sel == 2'b01, "R2 levels after start",
            {busy, vpp_sel, vcc_sel}, 5'b10101);
        n = 0;
        while (!img_req && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == SETTLE, "R2 settle before first request", n, SETTLE);
        n = 0;
        corrupted = 0;
        while (!done && n < 20000) begin
            n++;
            if (poke_start && n == 40) start = 1'b1;
            else start = 1'b0;
            if (corrupt >= 0 && !corrupted && vcc_sel == 2'b10) begin
                mem[corrupt] = img[corrupt] & 8'h7F;
                corrupted = 1;
            end
            @(negedge clk);
        end
        start = 1'b0;
        sb_close();
        chk(q.size() == 0, "R6 all expected addresses pulsed", q.size(), 0);
        q.delete();
        chk(done && !busy, "R13 done and idle", {done, busy}, 2'b10);
        chk(fail == exp_fail, "R8/R9/R12 fail flag", fail, exp_fail);
        if (exp_fail) chk(int'(fail_addr) == exp_fa, "R8/R9/R12 fail address", fail_addr, exp_fa);
        chk(exp_ca == exp_cpass, "R11 check pass coverage", exp_ca, exp_cpass);
        repeat (3) @(negedge clk);
        chk(done && fail == exp_fail && vpp_sel == 2'b00 && vcc_sel == 2'b00 && ce_n,
            "R13 results hold, supplies nominal", {done, fail, vpp_sel, vcc_sel, ce_n},
            {1'b1, exp_fail, 5'b00001});
    endtask

    initial begin
        setup(1);
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && pgm_n && !dq_oe && !busy && !done && !fail &&
            vpp_sel == 2'b00 && vcc_sel == 2'b00, "R1 reset state",
            {ce_n, oe_n, pgm_n, dq_oe, busy, done, fail}, 7'b1110000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // clean run, one address needs exactly the cap, start poked mid run
        run_case(DEPTH - 1, 0, 0, -1, 1, DEPTH);
        // pulse cap reached at address 5
        setup(2);
        run_case(5, 1, 5, -1, 0, 0);
        // bit that cannot be set back to one at address 2
        setup(3);
        run_case(2, 1, 2, -1, 0, 0);
        // check pass finds address 6 disturbed
        setup(4);
        run_case(DEPTH - 1, 1, 6, 6, 0, 7);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule